// File: doc/BRIEF.md
# Standby Wakeup Flag Controller

This block gathers a vector of asynchronous wakeup requests on the always-on clock and turns them into one sticky wakeup flag. Each request line has its own enable bit. Software clears the flag with a one-cycle clear strobe. A small sequencer tracks the standby state. It issues a single-cycle wake pulse to the power controller once the flag is set while standby is active.

Each request is first brought onto the clock through a two-flop synchroniser. It then gets its own rising-edge detector, placed in front of the OR that feeds the flag. The history register of each detector is updated whether or not that line is enabled. Because of this, a line that sits high can never hide a fresh edge on another line, and flipping an enable bit never counts as an edge. When standby is requested while an enabled line is already high, the request is treated as pending and the flag is set at once, so the part never sleeps on a wake condition it cannot see.

The sequencer has three states. `ST_RUN` is normal operation. `ST_SLEEP` is standby. `ST_WAKE` is a one-cycle exit state. The transitions are:
- entry: `ST_RUN` moves to `ST_SLEEP` on a standby request.
- trigger: `ST_SLEEP` moves to `ST_WAKE` while the flag is set.
- return: `ST_WAKE` moves back to `ST_RUN` unconditionally.

A standby request seen in `ST_SLEEP` or `ST_WAKE` has no effect.

Top module: `wkf_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `wake_flag_o` is 0 and `wake_pulse_o` is 0, and the sequencer is in `ST_RUN`.
- R2: A rising edge on an enabled line of `wake_src_i`, held stable, makes `wake_flag_o` read 1 after the third rising clock edge that follows the change, and not earlier.
- R3: A rising edge on a line whose bit in `wake_en_i` is 0 leaves `wake_flag_o` unchanged.
- R4: A rising edge on one enabled line sets the flag even while another enabled line is held high.
- R5: Clearing an enable bit while its line is high, or setting it again while the line is still high, creates no edge and leaves the flag at 0.
- R6: A pulse on `flag_clr_i` with no new edge and no standby entry in the same cycle makes `wake_flag_o` read 0 after the next clock edge.
- R7: When a clear and a new edge fall in the same cycle, the flag stays 1.
- R8: Entering standby while the flag is already 1 produces `wake_pulse_o` = 1 in the second cycle after the request edge, and the sequencer then returns to `ST_RUN`.
- R9: A standby request accepted in `ST_RUN` while any enabled synchronised line is high sets the flag on that edge, which leads to an immediate wake.
- R10: `wake_pulse_o` is never high for two cycles in a row, and it is never issued while the sequencer is in `ST_RUN` (a flag that rises in `ST_RUN` gives no pulse).
- R11: A new edge that arrives during `ST_SLEEP` sets the flag, and `wake_pulse_o` follows one cycle after the flag rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wake_src_i | input | NUM_SRC | Asynchronous wakeup request lines |
| wake_en_i | input | NUM_SRC | Per-line enable, 1 = line may set the flag |
| flag_clr_i | input | 1 | Software clear strobe for the flag |
| stby_req_i | input | 1 | Request to enter standby |
| wake_flag_o | output | 1 | Sticky wakeup flag |
| wake_pulse_o | output | 1 | One-cycle wake pulse to the power controller |

## Verification
Faults in the edge history or the synchroniser show up at `wake_flag_o`. The flag either rises a cycle early or late against the fixed three-edge latency, or it rises on an enable toggle when it should not. Both are visible within three cycles of the stimulus. Faults in the sequencer show as a missing pulse, a doubled pulse, or a pulse without standby. These are visible one or two cycles after the flag or the request. Random traffic with stuck-high lines, clears and standby requests is compared every cycle against a bench model of these rules.

// File: rtl/wkf_pkg.sv
package wkf_pkg;

    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SLEEP = 2'd1,
        ST_WAKE  = 2'd2
    } wkf_state_e;

endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= d_i;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) chain_q[s] <= '0;
            else         chain_q[s] <= chain_q[s-1];
        end
    end

    assign q_o = chain_q[LAST];

endmodule

// File: rtl/wkf_edge.sv
module wkf_edge #(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] lvl_i,
    input  logic [WIDTH-1:0] en_i,
    output logic [WIDTH-1:0] rise_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_line
        logic hist_q;

        // history follows the line whatever the enable does
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) hist_q <= 1'b0;
            else         hist_q <= lvl_i[b];
        end

        assign rise_o[b] = lvl_i[b] & ~hist_q & en_i[b];

        // R5
        en_toggle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (en_i[b] && !$past(en_i[b]) && lvl_i[b] && $past(lvl_i[b])) |-> !rise_o[b]);

        // R3
        masked_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !en_i[b] |-> !rise_o[b]);
    end

endmodule

// File: rtl/wkf_seq.sv
module wkf_seq
    import wkf_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic stby_req_i,
    input  logic flag_i,
    output logic entry_o,
    output logic pulse_o
);
    wkf_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:   if (stby_req_i) state_d = ST_SLEEP;
            ST_SLEEP: if (flag_i)     state_d = ST_WAKE;
            ST_WAKE:                  state_d = ST_RUN;
            default:                  state_d = ST_RUN;
        endcase
    end

    always_comb begin
        entry_o = 1'b0;
        pulse_o = 1'b0;
        unique case (state_q)
            ST_RUN:   entry_o = stby_req_i;
            ST_SLEEP: ;
            ST_WAKE:  pulse_o = 1'b1;
            default:  ;
        endcase
    end

    // R8
    sleep_trigger_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SLEEP && flag_i) |=> pulse_o);

    // R10
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

    // R10
    pulse_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN) |=> !pulse_o);

endmodule

// File: rtl/wkf_ctrl.sv
module wkf_ctrl #(
    parameter int NUM_SRC     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] wake_src_i,
    input  logic [NUM_SRC-1:0] wake_en_i,
    input  logic               flag_clr_i,
    input  logic               stby_req_i,
    output logic               wake_flag_o,
    output logic               wake_pulse_o
);
    logic [NUM_SRC-1:0] src_sync;
    logic [NUM_SRC-1:0] src_rise;
    logic               entry;
    logic               entry_pending;
    logic               flag_q;

    wkf_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .d_i   (wake_src_i),
        .q_o   (src_sync)
    );

    wkf_edge #(.WIDTH(NUM_SRC)) u_edge (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .lvl_i (src_sync),
        .en_i  (wake_en_i),
        .rise_o(src_rise)
    );

    wkf_seq u_seq (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .stby_req_i(stby_req_i),
        .flag_i    (flag_q),
        .entry_o   (entry),
        .pulse_o   (wake_pulse_o)
    );

    assign entry_pending = entry & (|(src_sync & wake_en_i));

    // setting beats clearing
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                       flag_q <= 1'b0;
        else if (|src_rise || entry_pending) flag_q <= 1'b1;
        else if (flag_clr_i)               flag_q <= 1'b0;
    end

    assign wake_flag_o = flag_q;

    // R7
    edge_sets_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|src_rise) |=> wake_flag_o);

    // R6
    clear_drops_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_clr_i && !(|src_rise) && !entry_pending) |=> !wake_flag_o);

    // R9
    entry_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        entry_pending |=> wake_flag_o);

    // R3
    flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wake_flag_o && !(|src_rise) && !entry_pending) |=> !wake_flag_o);

endmodule

// File: tb/wkf_ctrl_tb.sv
module wkf_ctrl_tb_top;
    localparam int N = 4;

    logic         clk_i = 1'b0;
    logic         rst_ni = 1'b0;
    logic [N-1:0] wake_src_i = '0;
    logic [N-1:0] wake_en_i = '0;
    logic         flag_clr_i = 1'b0;
    logic         stby_req_i = 1'b0;
    logic         wake_flag_o;
    logic         wake_pulse_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // bench model of the requirements
    logic [N-1:0] m_s1, m_s2, m_prev;
    logic         m_flag;
    int           m_st;   // 0 run, 1 sleep, 2 wake

    always #2 clk_i = ~clk_i;

    wkf_ctrl #(.NUM_SRC(N), .SYNC_STAGES(2)) dut_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wake_src_i  (wake_src_i),
        .wake_en_i   (wake_en_i),
        .flag_clr_i  (flag_clr_i),
        .stby_req_i  (stby_req_i),
        .wake_flag_o (wake_flag_o),
        .wake_pulse_o(wake_pulse_o)
    );

    task automatic expect_bit(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic void model_reset();
        m_s1 = '0; m_s2 = '0; m_prev = '0; m_flag = 1'b0; m_st = 0;
    endfunction

    function automatic void model_adv();
        logic [N-1:0] rise;
        logic         lvl;
        logic         f_n;
        int           st_n;
        rise = m_s2 & ~m_prev & wake_en_i;
        lvl  = (m_st == 0 && stby_req_i) ? |(m_s2 & wake_en_i) : 1'b0;
        f_n  = (|rise) | lvl | (m_flag & ~flag_clr_i);
        case (m_st)
            0:       st_n = stby_req_i ? 1 : 0;
            1:       st_n = m_flag ? 2 : 1;
            default: st_n = 0;
        endcase
        m_prev = m_s2; m_s2 = m_s1; m_s1 = wake_src_i;
        m_flag = f_n; m_st = st_n;
    endfunction

    // one clock: model follows the inputs held now, outputs compared at negedge
    task automatic step(input string tag);
        model_adv();
        @(negedge clk_i);
        expect_bit(wake_flag_o, m_flag, tag, "flag");
        expect_bit(wake_pulse_o, (m_st == 2), tag, "pulse");
    endtask

    task automatic steps(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(negedge clk_i);
        // R1 reset state
        expect_bit(wake_flag_o, 1'b0, "R1", "flag in reset");
        expect_bit(wake_pulse_o, 1'b0, "R1", "pulse in reset");
        rst_ni = 1'b1;
        steps(2, "R1");
        expect_bit(wake_flag_o, 1'b0, "R1", "flag after reset");

        // R2 latency of three edges
        wake_en_i = 4'b1111;
        wake_src_i[0] = 1'b1;
        step("R2");
        step("R2");
        expect_bit(wake_flag_o, 1'b0, "R2", "flag two edges after");
        step("R2");
        expect_bit(wake_flag_o, 1'b1, "R2", "flag three edges after");

        // R6 clear while line 0 stays high
        flag_clr_i = 1'b1; step("R6"); flag_clr_i = 1'b0;
        expect_bit(wake_flag_o, 1'b0, "R6", "flag after clear");
        steps(3, "R6");
        expect_bit(wake_flag_o, 1'b0, "R4", "held line gives no edge");

        // R4 edge on line 1 while line 0 is stuck high
        wake_src_i[1] = 1'b1;
        steps(3, "R4");
        expect_bit(wake_flag_o, 1'b1, "R4", "edge beside stuck line");
        flag_clr_i = 1'b1; step("R6"); flag_clr_i = 1'b0;

        // R5 enable toggles while line 0 high
        wake_en_i[0] = 1'b0; steps(3, "R5");
        wake_en_i[0] = 1'b1; steps(3, "R5");
        expect_bit(wake_flag_o, 1'b0, "R5", "enable toggle while high");

        // R3 masked line
        wake_en_i[2] = 1'b0; wake_src_i[2] = 1'b1;
        steps(5, "R3");
        expect_bit(wake_flag_o, 1'b0, "R3", "disabled line edge");
        wake_en_i[2] = 1'b1; steps(2, "R3");
        expect_bit(wake_flag_o, 1'b0, "R5", "enable after masked rise");

        // R7 clear in the same cycle as a new edge; flag already 1 and 0 cases
        wake_src_i[3] = 1'b1; step("R7"); step("R7");
        flag_clr_i = 1'b1; step("R7"); flag_clr_i = 1'b0;
        expect_bit(wake_flag_o, 1'b1, "R7", "edge wins over clear");
        // R10 flag rose in run: no pulse
        expect_bit(wake_pulse_o, 1'b0, "R10", "no pulse in run");

        // R8 standby entry with flag set
        stby_req_i = 1'b1; step("R8"); stby_req_i = 1'b0;
        expect_bit(wake_pulse_o, 1'b0, "R8", "pulse one cycle after entry");
        step("R8");
        expect_bit(wake_pulse_o, 1'b1, "R8", "pulse two cycles after entry");
        step("R10");
        expect_bit(wake_pulse_o, 1'b0, "R10", "pulse one cycle wide");

        // R11 edge during sleep
        wake_src_i = '0; flag_clr_i = 1'b1; step("R11"); flag_clr_i = 1'b0;
        steps(3, "R11");
        stby_req_i = 1'b1; step("R11"); stby_req_i = 1'b0;
        steps(4, "R11");
        expect_bit(wake_pulse_o, 1'b0, "R11", "sleep without event");
        wake_src_i[2] = 1'b1;
        steps(3, "R11");
        expect_bit(wake_flag_o, 1'b1, "R11", "flag from sleep edge");
        expect_bit(wake_pulse_o, 1'b0, "R11", "pulse not yet");
        step("R11");
        expect_bit(wake_pulse_o, 1'b1, "R11", "pulse after flag");
        step("R11");

        // R9 entry while an enabled line is high, flag clear
        flag_clr_i = 1'b1; step("R9"); flag_clr_i = 1'b0;
        steps(2, "R9");
        expect_bit(wake_flag_o, 1'b0, "R9", "flag before entry");
        stby_req_i = 1'b1; step("R9"); stby_req_i = 1'b0;
        expect_bit(wake_flag_o, 1'b1, "R9", "flag at entry");
        step("R9");
        expect_bit(wake_pulse_o, 1'b1, "R9", "immediate wake");
        step("R9");

        // random traffic against the model
        for (int k = 0; k < 4000; k++) begin
            for (int b = 0; b < N; b++) begin
                if ($urandom_range(0, 9) == 0) wake_src_i[b] = ~wake_src_i[b];
                if ($urandom_range(0, 29) == 0) wake_en_i[b] = ~wake_en_i[b];
            end
            flag_clr_i = ($urandom_range(0, 7) == 0);
            stby_req_i = ($urandom_range(0, 11) == 0);
            step("R2");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule